// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves words between one peripheral and memory over a shared bus without processor involvement. Software programs a start address, a byte count, a legal address window, the peripheral's port address, the transfer style and the interrupt enables through a small register port. A transfer is then launched either by a pulse on the peripheral request line or by a software "go" write. Before any bus cycle the controller raises a bus request and waits for the grant. Each bus cycle presents an address, a write flag and a strobe, and lasts until the target acknowledges.

There are two data paths. In buffered mode each item takes two bus cycles: a read of the source into an internal holding register, then a write of that register to the destination. In fly-by mode the controller issues only the memory address and raises a peripheral acknowledge line, so the peripheral drives or takes the data bus itself. The address generator adds an offset to the start address and steps it by one word after each item. When the block ends, or when an address error stops the channel, the offset returns to zero, so the next block begins again at the start address.

A block moves either all at once under a single trigger, or one item per trigger with the bus released between items. Completion and address errors set sticky status flags. These flags drive the interrupt output through their enables and are cleared by writing ones to them.

Top module: `dma_chan`

## Requirements
- R1: After reset the bus request, strobe, peripheral acknowledge and interrupt are low, status (offset 6) reads 0, the current-address view (offset 7) reads 0, the window low bound (offset 4) reads 0 and the window high bound (offset 5) reads all ones.
- R2: Register offsets are 0 control, 1 start address, 2 byte count, 3 peripheral port address, 4 window low, 5 window high, 6 status, 7 current address (read only). Offsets 1 to 5 read back what was written while the channel is idle. Writes to offsets 0 to 5 are ignored while the channel is busy, which includes the time between items of a block that is moved one item per trigger.
- R3: In the control register, bit 0 is go, bit 1 selects whole-block mode, bit 2 selects fly-by mode, bit 3 sets the direction to memory-to-peripheral, bit 4 enables the done interrupt and bit 5 enables the error interrupt. A go write or a high peripheral request starts the channel. With a byte count of zero the block completes at once: the done flag is set and no bus request is raised.
- R4: No strobe is issued unless the bus request and grant are both high. Once raised, a bus request stays high until the grant arrives. Strobe, address and write flag stay stable until the acknowledge.
- R5: In buffered mode each item reads its source (write flag low) and then writes the captured word to its destination (write flag high). With direction bit 0 the source is the peripheral port address and the destination is the generated memory address. With direction bit 1 these are swapped.
- R6: In fly-by mode each item is one bus cycle on the generated memory address with the peripheral acknowledge high. The write flag is high for peripheral-to-memory and low for memory-to-peripheral.
- R7: One item is one 4-byte word. The generated address advances by 4 per item, and a block holds ceil(count/4) items.
- R8: After a block completes or stops on an error, the current address returns to the start address, so a repeated block rewrites the same locations.
- R9: In one-item-per-trigger mode each trigger moves exactly one item, and the bus request is low between items. The channel reports busy until the final item is done.
- R10: An item whose generated address is not 4-byte aligned, or is not inside the inclusive window, is not issued. The channel stops, sets the error flag, moves no further items and raises no done flag.
- R11: Status bit 0 is done, bit 1 is error and bit 2 is busy. Done and error are sticky and are cleared by writing 1 to their bit. The interrupt output is (done AND done-enable) OR (error AND error-enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register offset |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Register read data for cfg_addr_i |
| periph_req_i | input | 1 | Peripheral transfer request |
| periph_ack_o | output | 1 | Fly-by peripheral select/acknowledge |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_addr_o | output | AW | Bus address |
| mem_we_o | output | 1 | Bus write flag |
| mem_stb_o | output | 1 | Bus strobe |
| mem_ack_i | input | 1 | Bus cycle acknowledge |
| mem_wdata_o | output | DW | Write data from the holding register |
| mem_rdata_i | input | DW | Read data |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check the bus handshake on every cycle: no strobe without request and grant, a request held until it is granted, and strobe, address and write flag stable while the acknowledge is pending. They also check that fly-by cycles stay inside the window and are aligned, that the interrupt stays up without a register write, and that a zero count never leads to a bus request. Only the bench's scenarios can show the data itself: the order in which items are read and written, the item count for uneven byte counts, the reload to the start address, and the release of the bus between single items. The same holds for the partial moves before a window error and for writes being ignored while busy.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_FLY, ST_UPD
  } st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_BASE = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_PADR = 3'd3;
  localparam logic [2:0] REG_WLO  = 3'd4;
  localparam logic [2:0] REG_WHI  = 3'd5;
  localparam logic [2:0] REG_STAT = 3'd6;
  localparam logic [2:0] REG_CUR  = 3'd7;

  // packed from control bit 5 down to bit 1
  typedef struct packed {
    logic ie_err;
    logic ie_done;
    logic to_periph;
    logic flyby;
    logic block;
  } ctrl_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          set_done_i,
  input  logic          set_err_i,
  input  logic [AW-1:0] cur_addr_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] paddr_o,
  output logic [AW-1:0] win_lo_o,
  output logic [AW-1:0] win_hi_o,
  output logic [CW-1:0] count_o,
  output logic          go_o,
  output logic          irq_o
);
  logic done_q, err_q;
  logic cfg_ok, stat_wr;

  assign cfg_ok  = we_i && !busy_i;
  assign stat_wr = we_i && (addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      base_o   <= '0;
      paddr_o  <= '0;
      win_lo_o <= '0;
      win_hi_o <= '1;
      count_o  <= '0;
      go_o     <= 1'b0;
    end else begin
      go_o <= cfg_ok && (addr_i == REG_CTRL) && wdata_i[0];
      if (cfg_ok) begin
        unique case (addr_i)
          REG_CTRL: ctrl_o   <= wdata_i[5:1];
          REG_BASE: base_o   <= wdata_i[AW-1:0];
          REG_CNT:  count_o  <= wdata_i[CW-1:0];
          REG_PADR: paddr_o  <= wdata_i[AW-1:0];
          REG_WLO:  win_lo_o <= wdata_i[AW-1:0];
          REG_WHI:  win_hi_o <= wdata_i[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  // sticky flags, set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= set_done_i || (done_q && !(stat_wr && wdata_i[0]));
      err_q  <= set_err_i  || (err_q  && !(stat_wr && wdata_i[1]));
    end
  end

  assign irq_o = (done_q && ctrl_o.ie_done) || (err_q && ctrl_o.ie_err);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o = DW'({ctrl_o, 1'b0});
      REG_BASE: rdata_o = DW'(base_o);
      REG_CNT:  rdata_o = DW'(count_o);
      REG_PADR: rdata_o = DW'(paddr_o);
      REG_WLO:  rdata_o = DW'(win_lo_o);
      REG_WHI:  rdata_o = DW'(win_hi_o);
      REG_STAT: rdata_o = DW'({busy_i, err_q, done_q});
      default:  rdata_o = DW'(cur_addr_i);
    endcase
  end
endmodule

// File: rtl/dma_chan_agen.sv
module dma_chan_agen #(
  parameter int unsigned AW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned UNIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] win_lo_i,
  input  logic [AW-1:0] win_hi_i,
  input  logic          step_i,
  input  logic          clear_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          legal_o,
  output logic          mid_o
);
  localparam int unsigned UB = $clog2(UNIT);

  logic [CW-1:0] ofs_q;
  logic [CW:0]   ofs_nx;
  logic [AW:0]   end_byte;
  logic          aligned;

  assign ofs_nx   = {1'b0, ofs_q} + (CW+1)'(UNIT);
  assign last_o   = ofs_nx >= {1'b0, count_i};
  assign addr_o   = base_i + AW'(ofs_q);
  assign end_byte = {1'b0, addr_o} + (AW+1)'(UNIT - 1);
  assign mid_o    = (ofs_q != '0);

  generate
    if (UB > 0) begin : g_align
      assign aligned = (addr_o[UB-1:0] == '0);
    end else begin : g_byte
      assign aligned = 1'b1;
    end
  endgenerate

  assign legal_o = aligned && (addr_o >= win_lo_i) && (end_byte <= {1'b0, win_hi_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ofs_q <= '0;
    else if (clear_i || (step_i && last_o)) ofs_q <= '0;
    else if (step_i)                    ofs_q <= ofs_nx[CW-1:0];
  end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic cnt_zero_i,
  input  logic legal_i,
  input  logic last_i,
  input  logic gnt_i,
  input  logic ack_i,
  input  logic block_i,
  input  logic flyby_i,
  output st_e  st_o,
  output logic step_o,
  output logic clear_o,
  output logic set_done_o,
  output logic set_err_o,
  output logic bus_req_o
);
  st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d       = st_q;
    step_o     = 1'b0;
    clear_o    = 1'b0;
    set_done_o = 1'b0;
    set_err_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (trig_i) begin
        if (cnt_zero_i) set_done_o = 1'b1;
        else            st_d = ST_REQ;
      end
      ST_REQ: begin
        if (!legal_i) begin
          set_err_o = 1'b1;
          clear_o   = 1'b1;
          st_d      = ST_IDLE;
        end else if (gnt_i) begin
          st_d = flyby_i ? ST_FLY : ST_RD;
        end
      end
      ST_RD:  if (ack_i) st_d = ST_WR;
      ST_WR,
      ST_FLY: if (ack_i) st_d = ST_UPD;
      ST_UPD: begin
        step_o = 1'b1;
        if (last_i) begin
          set_done_o = 1'b1;
          st_d       = ST_IDLE;
        end else begin
          st_d = block_i ? ST_REQ : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // block mode keeps the bus across UPD; single mode lets it go
  assign bus_req_o = ((st_q == ST_REQ) && legal_i)
                  || (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_FLY)
                  || ((st_q == ST_UPD) && block_i && !last_i);
  assign st_o = st_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  input  logic          periph_req_i,
  output logic          periph_ack_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_stb_o,
  input  logic          mem_ack_i,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          irq_o
);
  localparam int unsigned UNIT = DW / 8;

  ctrl_t         ctrl;
  logic [AW-1:0] base, paddr, win_lo, win_hi, gen_addr;
  logic [CW-1:0] cnt_bytes;
  logic          go, busy, set_done, set_err, step, clear;
  logic          last, legal, mid;
  st_e           cur_st;
  logic [DW-1:0] hold_q;

  assign busy = (cur_st != ST_IDLE) || mid;

  dma_chan_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .busy_i(busy), .set_done_i(set_done), .set_err_i(set_err), .cur_addr_i(gen_addr),
    .ctrl_o(ctrl), .base_o(base), .paddr_o(paddr), .win_lo_o(win_lo), .win_hi_o(win_hi),
    .count_o(cnt_bytes), .go_o(go), .irq_o(irq_o)
  );

  dma_chan_agen #(.AW(AW), .CW(CW), .UNIT(UNIT)) u_agen (
    .clk_i, .rst_ni,
    .base_i(base), .count_i(cnt_bytes), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .step_i(step), .clear_i(clear),
    .addr_o(gen_addr), .last_o(last), .legal_o(legal), .mid_o(mid)
  );

  dma_chan_fsm u_fsm (
    .clk_i, .rst_ni,
    .trig_i(go || periph_req_i), .cnt_zero_i(cnt_bytes == '0),
    .legal_i(legal), .last_i(last), .gnt_i(bus_gnt_i), .ack_i(mem_ack_i),
    .block_i(ctrl.block), .flyby_i(ctrl.flyby),
    .st_o(cur_st), .step_o(step), .clear_o(clear),
    .set_done_o(set_done), .set_err_o(set_err), .bus_req_o(bus_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            hold_q <= '0;
    else if ((cur_st == ST_RD) && mem_ack_i) hold_q <= mem_rdata_i;
  end

  always_comb begin
    unique case (cur_st)
      ST_RD:   mem_addr_o = ctrl.to_periph ? gen_addr : paddr;
      ST_WR:   mem_addr_o = ctrl.to_periph ? paddr : gen_addr;
      default: mem_addr_o = gen_addr;
    endcase
  end

  assign mem_stb_o    = (cur_st == ST_RD) || (cur_st == ST_WR) || (cur_st == ST_FLY);
  assign mem_we_o     = (cur_st == ST_WR) || ((cur_st == ST_FLY) && !ctrl.to_periph);
  assign periph_ack_o = (cur_st == ST_FLY);
  assign mem_wdata_o  = hold_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned LSB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          mem_stb_o,
  input logic          mem_ack_i,
  input logic          mem_we_o,
  input logic          periph_ack_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          irq_o,
  input logic          cfg_we_i,
  input logic [AW-1:0] win_lo,
  input logic [AW-1:0] win_hi,
  input logic [CW-1:0] cnt_bytes,
  input st_e           cur_st
);
  a_r4_stb_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stb_o |-> (bus_req_o && bus_gnt_i));

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);

  a_r4_cycle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_stb_o && !mem_ack_i) |=> (mem_stb_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r6_fly_ack_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_ack_o |-> mem_stb_o);

  a_r10_fly_addr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_stb_o && periph_ack_o) |->
      ((mem_addr_o >= win_lo) && (mem_addr_o <= win_hi) && (mem_addr_o[LSB-1:0] == '0)));

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cfg_we_i) |=> irq_o);

  a_r3_zero_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_st == ST_IDLE) && (cnt_bytes == '0)) |=> !bus_req_o);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW), .LSB($clog2(DW/8))) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .mem_stb_o(mem_stb_o), .mem_ack_i(mem_ack_i), .mem_we_o(mem_we_o),
  .periph_ack_o(periph_ack_o), .mem_addr_o(mem_addr_o), .irq_o(irq_o),
  .cfg_we_i(cfg_we_i), .win_lo(win_lo), .win_hi(win_hi),
  .cnt_bytes(cnt_bytes), .cur_st(cur_st)
);

// File: tb/dma_chan_tb_top.sv
module dma_chan_tb_top;
  localparam logic [15:0] PADR = 16'h03F0;
  localparam logic [15:0] WHI  = 16'h02FF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        preq = 1'b0, pack, breq, bgnt, mwe, mstb, mack, irq;
  logic [15:0] maddr;
  logic [31:0] mwdata, mrdata;
  logic        tick;
  int          n_chk = 0, n_fail = 0;
  int          n_stb = 0, n_req = 0, ps_cnt = 0, pw_n = 0;
  logic [31:0] mem  [256];
  logic [31:0] plog [256];

  always #5 clk = ~clk;

  dma_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .periph_req_i(preq),
    .periph_ack_o(pack), .bus_req_o(breq), .bus_gnt_i(bgnt), .mem_addr_o(maddr),
    .mem_we_o(mwe), .mem_stb_o(mstb), .mem_ack_i(mack), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .irq_o(irq)
  );

  function automatic logic [31:0] src_word(int idx);
    return 32'h5000_0000 + 32'(idx * 7);
  endfunction

  // bus model: grant one cycle after request, ack every other cycle
  wire [7:0] widx  = maddr[9:2];
  wire       hit_p = !pack && (maddr == PADR);
  assign mack   = mstb && tick;
  assign mrdata = hit_p ? (32'hC000_0000 + 32'(ps_cnt)) : mem[widx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bgnt <= 1'b0;
      tick <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= src_word(i);
    end else begin
      bgnt <= breq;
      tick <= ~tick;
      if (breq) n_req <= n_req + 1;
      if (mstb && mack) begin
        n_stb <= n_stb + 1;
        if (pack) begin
          if (mwe) begin mem[widx] <= 32'hC000_0000 + 32'(ps_cnt); ps_cnt <= ps_cnt + 1; end
          else begin plog[pw_n[7:0]] <= mem[widx]; pw_n <= pw_n + 1; end
        end else if (hit_p) begin
          if (mwe) begin plog[pw_n[7:0]] <= mwdata; pw_n <= pw_n + 1; end
          else ps_cnt <= ps_cnt + 1;
        end else if (mwe) begin
          mem[widx] <= mwdata;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    do rd(3'd6, s); while (s[2]);
  endtask

  task automatic pulse_req();
    @(negedge clk); preq = 1'b1;
    @(negedge clk); preq = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit go, bit blk, bit fly, bit top, bit ied, bit iee);
    return {26'd0, iee, ied, top, fly, blk, go};
  endfunction

  task automatic run_block(bit fly, bit top, bit blk, logic [15:0] base, int nbytes);
    int items = (nbytes + 3) / 4;
    int per = fly ? 1 : 2;
    int s0, ps0, pw0;
    logic [31:0] v;
    wr(3'd6, 32'h3);
    wr(3'd1, 32'(base));
    wr(3'd2, 32'(nbytes));
    s0 = n_stb; ps0 = ps_cnt; pw0 = pw_n;
    if (blk) begin
      wr(3'd0, ctl(1, 1, fly, top, 1, 1));
      wait_idle();
    end else begin
      wr(3'd0, ctl(0, 0, fly, top, 1, 1));
      for (int i = 0; i < items; i++) begin
        pulse_req();
        wait (n_stb == s0 + (i + 1) * per);
        repeat (2) @(negedge clk);
        chk("R9", "bus request low between items", 32'(breq), 0);
        rd(3'd6, v);
        chk("R9", "busy until last item", 32'(v[2]), 32'(i < items - 1));
      end
    end
    chk("R7", "bus cycles per block", 32'(n_stb - s0), 32'(items * per));
    for (int i = 0; i < items; i++) begin
      if (top) chk(fly ? "R6" : "R5", "word delivered to peripheral",
                   plog[8'(pw0 + i)], src_word(int'(base[9:2]) + i));
      else     chk(fly ? "R6" : "R5", "word stored in memory",
                   mem[8'(int'(base[9:2]) + i)], 32'hC000_0000 + 32'(ps0 + i));
    end
    rd(3'd6, v);
    chk("R11", "done flag after block", v, 32'h1);
    chk("R11", "done interrupt", 32'(irq), 1);
    rd(3'd7, v);
    chk("R8", "address reloaded to start", v, 32'(base));
  endtask

  initial begin
    logic [31:0] v;
    int s0, r0, ps0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "bus request", 32'(breq), 0);
    chk("R1", "strobe", 32'(mstb), 0);
    chk("R1", "peripheral ack", 32'(pack), 0);
    chk("R1", "irq", 32'(irq), 0);
    rd(3'd6, v); chk("R1", "status", v, 0);
    rd(3'd7, v); chk("R1", "current address", v, 0);
    rd(3'd4, v); chk("R1", "window low", v, 0);
    rd(3'd5, v); chk("R1", "window high", v, 32'hFFFF);
    // R2 readback
    wr(3'd3, 32'(PADR)); rd(3'd3, v); chk("R2", "port address readback", v, 32'(PADR));
    wr(3'd5, 32'(WHI));  rd(3'd5, v); chk("R2", "window high readback", v, 32'(WHI));
    wr(3'd4, 32'h0);     rd(3'd4, v); chk("R2", "window low readback", v, 0);
    wr(3'd2, 32'd13);    rd(3'd2, v); chk("R2", "count readback", v, 32'd13);
    // sweep of modes, directions and lengths (R5 R6 R7 R8 R9)
    for (int fly = 0; fly < 2; fly++)
      for (int top = 0; top < 2; top++)
        for (int blk = 0; blk < 2; blk++)
          for (int k = 1; k <= 5; k++)
            run_block(bit'(fly), bit'(top), bit'(blk),
                      top ? 16'h0200 : 16'(16'h0040 + 4 * k), 4 * k - (k % 2));
    // R8 repeated block on the same start address
    run_block(0, 0, 1, 16'h0080, 8);
    run_block(0, 0, 1, 16'h0080, 8);
    // R3 zero count: done at once, no bus request
    wr(3'd6, 32'h3); wr(3'd2, 32'd0);
    r0 = n_req;
    wr(3'd0, ctl(1, 1, 0, 0, 1, 1));
    repeat (4) @(negedge clk);
    chk("R3", "no bus request for zero count", 32'(n_req - r0), 0);
    rd(3'd6, v); chk("R3", "zero count done", v, 32'h1);
    chk("R3", "zero count irq", 32'(irq), 1);
    // R11 enable off: flag set, no irq; peripheral trigger path
    wr(3'd6, 32'h3); wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
    pulse_req(); repeat (2) @(negedge clk);
    rd(3'd6, v); chk("R11", "done without enable", v, 32'h1);
    chk("R11", "irq masked", 32'(irq), 0);
    // R10 misaligned start
    wr(3'd6, 32'h3); wr(3'd2, 32'd8); wr(3'd1, 32'h0042);
    s0 = n_stb;
    wr(3'd0, ctl(1, 1, 0, 0, 1, 1)); wait_idle();
    chk("R10", "no cycles when misaligned", 32'(n_stb - s0), 0);
    rd(3'd6, v); chk("R10", "error flag misaligned", v, 32'h2);
    chk("R10", "error irq", 32'(irq), 1);
    wr(3'd6, 32'h2);
    rd(3'd6, v); chk("R11", "error cleared by write-one", v, 0);
    chk("R11", "irq cleared", 32'(irq), 0);
    // R10 outside window, error irq disabled
    wr(3'd1, 32'h0304); s0 = n_stb;
    wr(3'd0, ctl(1, 1, 1, 0, 1, 0)); wait_idle();
    chk("R10", "no cycles outside window", 32'(n_stb - s0), 0);
    rd(3'd6, v); chk("R10", "error flag outside window", v, 32'h2);
    chk("R11", "error irq masked", 32'(irq), 0);
    // R10 block running past the window end
    wr(3'd6, 32'h3); wr(3'd1, 32'h02F8); wr(3'd2, 32'd16);
    s0 = n_stb; ps0 = ps_cnt;
    wr(3'd0, ctl(1, 1, 0, 0, 1, 1)); wait_idle();
    chk("R10", "two items before the window end", 32'(n_stb - s0), 4);
    chk("R10", "first item stored", mem[190], 32'hC000_0000 + 32'(ps0));
    chk("R10", "second item stored", mem[191], 32'hC000_0000 + 32'(ps0 + 1));
    rd(3'd6, v); chk("R10", "error without done", v, 32'h2);
    rd(3'd7, v); chk("R8", "reload after error", v, 32'h02F8);
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk("R11", "done write-one keeps error", v, 32'h2);
    // R2 writes ignored mid-block in single mode
    wr(3'd6, 32'h3); wr(3'd1, 32'h0020); wr(3'd2, 32'd12);
    wr(3'd0, ctl(0, 0, 0, 0, 1, 1));
    s0 = n_stb; ps0 = ps_cnt;
    pulse_req(); wait (n_stb == s0 + 2); repeat (2) @(negedge clk);
    wr(3'd1, 32'h0100);
    rd(3'd1, v); chk("R2", "start address kept while busy", v, 32'h0020);
    wr(3'd0, ctl(1, 1, 0, 0, 0, 0));
    rd(3'd0, v); chk("R2", "control kept while busy", v, 32'h30);
    pulse_req(); wait (n_stb == s0 + 4); repeat (2) @(negedge clk);
    pulse_req(); wait_idle();
    chk("R2", "third item at original address", mem[10], 32'hC000_0000 + 32'(ps0 + 2));
    rd(3'd6, v); chk("R9", "done after last single item", v, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule